// File: doc/BRIEF.md
# One-Hot Overlapping 1011 Sequence Detector

This block watches a serial bit stream, one bit per rising clock edge. It raises a single-bit flag when the four most recent bits form the pattern 1011, with the oldest bit first. Matches may overlap: the tail of one match can start the next, so in the stream 1011011 the flag rises twice.

The state is held one-hot in five flip-flops:

| Index | Meaning |
|---|---|
| 0 | Nothing matched |
| 1 | Matched "1" |
| 2 | Matched "10" |
| 3 | Matched "101" |
| 4 | Full pattern matched |

Each flip-flop's next value is a hand-written sum of products over the state bits and the serial input. Because only one state bit is ever set, each product term uses a single state bit.

The flag is the full-match state bit itself (Moore style), so it can change only at a clock edge or at reset. An active-low asynchronous reset forces the "nothing matched" state without waiting for a clock.

Top module: `seqDetTop`

## Requirements
- R1: While `rstN` is low, `matchFlag` is 0. Asserting `rstN` drives `matchFlag` low at once, without a clock edge.
- R2: When the bits sampled on four successive rising edges are 1, 0, 1, 1 (in that order), `matchFlag` is 1 from the fourth of those edges until the next rising edge.
- R3: `matchFlag` is never high for two consecutive cycles; each match gives a one-cycle pulse.
- R4: Overlapping matches are found. The stream 1011011 gives pulses after the 4th bit and after the 7th bit, and nowhere else.
- R5: A run of 1s never gives a match by itself. After a match, a following 1 restarts the search from "1", so 1011 1011 gives two pulses.
- R6: The prefix 10 followed by 1011 (101011) gives exactly one pulse, after the 6th bit.
- R7: Exactly one of the five state bits is set at every clock edge after reset.
- R8: On any bit stream, `matchFlag` after each edge equals 1 exactly when the last four bits sampled since reset are 1011.
- R9: Reset discards earlier history. Bits sampled before reset never contribute to a match after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit is sampled on each rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| serialIn | input | 1 | Serial data bit |
| matchFlag | output | 1 | High for one cycle after the pattern 1011 completes |

## Verification
The design has no tunable parameters, because the pattern and the five-state encoding fix every width. The bench therefore builds it exactly as written.

Directed streams reach each transition out of every state:
- the full-match state, left on both a 0 and a 1;
- the "101" state, falling back on a 0;
- the "10" state, dropping to idle on a 0.

A long pseudo-random stream is compared against a four-bit history model. A reset applied while the flag is high checks the asynchronous clear, and a reset in mid-pattern checks that earlier history is lost.

// File: rtl/seqDetPkg.sv
package seqDetPkg;
  localparam int STATE_COUNT = 5;
  localparam int IDX_NONE = 0;
  localparam int IDX_ONE = 1;
  localparam int IDX_ONE_ZERO = 2;
  localparam int IDX_ONE_ZERO_ONE = 3;
  localparam int IDX_FULL = 4;
  localparam logic [STATE_COUNT-1:0] RESET_HOT = STATE_COUNT'(1) << IDX_NONE;

  typedef struct packed {
    logic [STATE_COUNT-1:0] loadHot;
  } ctrlStrobes_t;
endpackage

// File: rtl/seqDetNext.sv
module seqDetNext
  import seqDetPkg::*;
(
  input  logic                   serialIn,
  input  logic [STATE_COUNT-1:0] stateHot,
  output ctrlStrobes_t           strobes
);
  logic bitOne;
  logic bitZero;

  assign bitOne = serialIn;
  assign bitZero = ~serialIn;

  always_comb begin
    strobes.loadHot[IDX_NONE] = (stateHot[IDX_NONE] & bitZero)
                              | (stateHot[IDX_ONE_ZERO] & bitZero);
    strobes.loadHot[IDX_ONE] = (stateHot[IDX_NONE] & bitOne)
                             | (stateHot[IDX_ONE] & bitOne)
                             | (stateHot[IDX_FULL] & bitOne);
    strobes.loadHot[IDX_ONE_ZERO] = (stateHot[IDX_ONE] & bitZero)
                                  | (stateHot[IDX_ONE_ZERO_ONE] & bitZero)
                                  | (stateHot[IDX_FULL] & bitZero);
    strobes.loadHot[IDX_ONE_ZERO_ONE] = stateHot[IDX_ONE_ZERO] & bitOne;
    strobes.loadHot[IDX_FULL] = stateHot[IDX_ONE_ZERO_ONE] & bitOne;
  end
endmodule

// File: rtl/seqDetStateReg.sv
module seqDetStateReg
  import seqDetPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  output logic [STATE_COUNT-1:0] stateHot
);
  for (genvar i = 0; i < STATE_COUNT; i++) begin : gBit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stateHot[i] <= RESET_HOT[i];
      else       stateHot[i] <= strobes.loadHot[i];
    end
  end

  // R7: the register must stay one-hot
  assert_one_hot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stateHot) == 1);
endmodule

// File: rtl/seqDetTop.sv
module seqDetTop
  import seqDetPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic serialIn,
  output logic matchFlag
);
  logic [STATE_COUNT-1:0] stateHot;
  ctrlStrobes_t           strobes;

  seqDetNext u_next (
    .serialIn (serialIn),
    .stateHot (stateHot),
    .strobes  (strobes)
  );

  seqDetStateReg u_state (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .stateHot (stateHot)
  );

  assign matchFlag = stateHot[IDX_FULL];

  // R1: flag low whenever reset is held
  assert_reset_low_R1: assert property (@(posedge clk) !rstN |-> !matchFlag);

  // R2: "101" state plus a 1 completes the match
  assert_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateHot[IDX_ONE_ZERO_ONE] && serialIn) |=> matchFlag);

  // R3: one-cycle pulse
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    matchFlag |=> !matchFlag);

  // R4: after a match, a 0 keeps the "10" suffix alive
  assert_overlap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && !serialIn) |=> stateHot[IDX_ONE_ZERO]);
endmodule

// File: tb/sim_seqDetTop.sv
module sim_seqDetTop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serialIn = 1'b0;
  logic matchFlag;
  logic [3:0] hist = 4'b0000;
  int vectors = 0;
  int fails = 0;
  logic finished = 1'b0;

  seqDetTop u0 (
    .clk       (clk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .matchFlag (matchFlag)
  );

  always #2 clk = ~clk;

  task automatic checkVal(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: matchFlag=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // drive one bit, sample after the edge, compare with history model (R8)
  task automatic applyBit(string req, logic b);
    @(negedge clk);
    serialIn = b;
    @(posedge clk);
    #1;
    hist = {hist[2:0], b};
    checkVal(req, matchFlag, hist == 4'b1011);
  endtask

  task automatic applyStream(string req, int n, logic [31:0] bits);
    for (int i = n - 1; i >= 0; i--) applyBit(req, bits[i]);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkVal("R1", matchFlag, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    hist = 4'b0000;
  endtask

  task automatic testResetState();
    doReset();
    applyBit("R1", 1'b0);
  endtask

  task automatic testSingle();
    doReset();
    applyStream("R2", 4, 32'b1011);
    applyBit("R3", 1'b0);
    applyBit("R3", 1'b0);
  endtask

  task automatic testOverlap();
    doReset();
    applyStream("R4", 7, 32'b1011011);
    applyBit("R4", 1'b0);
  endtask

  task automatic testOnes();
    doReset();
    applyStream("R5", 8, 32'hFF);
    applyStream("R5", 8, 32'b10111011);
    applyStream("R5", 5, 32'b11111);
  endtask

  task automatic testTenPrefix();
    doReset();
    applyStream("R6", 6, 32'b101011);
    applyStream("R6", 3, 32'b100);
  endtask

  task automatic testAsyncReset();
    doReset();
    applyStream("R1", 4, 32'b1011);
    #1;
    rstN = 1'b0;
    #0.5;
    checkVal("R1", matchFlag, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    hist = 4'b0000;
    applyBit("R1", 1'b0);
  endtask

  task automatic testHistoryLoss();
    doReset();
    applyStream("R9", 2, 32'b10);
    doReset();
    applyStream("R9", 2, 32'b11);
    applyStream("R9", 3, 32'b011);
  endtask

  task automatic testRandom();
    logic [15:0] lfsr = 16'hACE1;
    doReset();
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      applyBit("R8", lfsr[0]);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #1;
    checkVal("R1", matchFlag, 1'b0);
    testResetState();
    testSingle();
    testOverlap();
    testOnes();
    testTenPrefix();
    testAsyncReset();
    testHistoryLoss();
    testRandom();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule